// File: doc/BRIEF.md
# Interrupt Claim/Complete Controller

This block collects interrupt requests from a set of peripheral source lines and presents them to a small number of target contexts, such as processor cores. A rising edge on a source line latches that source as pending. Each source carries a programmable priority. Each context has its own enable bitmap and a priority threshold. The block drives one interrupt line per context, and that line is high whenever the context has an eligible source whose priority is above its threshold.

Software works with the block over a simple single-beat register bus. A read of a context's claim register has side effects. It returns the ID of the best eligible source, removes that source from the pending set and marks it as in service (claimed). While a source is claimed, it cannot be offered to any context, and new edges on its line are dropped. When the handler finishes, it writes the same ID back to the claim register. That write releases the source, and the source can then be raised again by a fresh edge.

Source IDs run from 1 to 31, and ID 0 means "nothing". Register map (byte addresses, all accesses 32-bit and word aligned):
- 0x000000 + 4*(n-1): priority of source n.
- 0x001000: pending word, where bit n is source n.
- 0x002000 + 0x80*c: enable word of context c, where bit n is source n.
- 0x200000 + 0x1000*c: threshold of context c.
- 0x200004 + 0x1000*c: claim register of context c.

Top module: `irq_claim_ctrl`

## Requirements
- R1: A source is eligible for context c only when it is pending, not claimed, and its bit is set in the enable word of context c.
- R2: A context's selected source is the eligible source with the highest priority that is strictly greater than the context's threshold. On a tie, the lowest ID is selected. If no source qualifies, the selected ID is 0.
- R3: irq_o[c] is high exactly when the selected ID of context c is non-zero. It reflects the register state of the previous cycle (one cycle of latency).
- R4: A read of the claim register returns the selected ID on rd_data_o on the cycle after the request. When that ID is non-zero, the read also clears the source's pending bit and sets its claimed bit. When the ID is 0, nothing changes.
- R5: A write of value v to any context's claim register clears the claimed bit of source v when v < 32. A write of any larger value is ignored.
- R6: A priority write stores only wdata[2:0]. The word at offset 4*k belongs to source k+1, and a read returns the stored 3-bit value zero-extended.
- R7: A threshold write takes effect only when the written 32-bit value is at most 7. Otherwise the stored threshold is unchanged.
- R8: The pending word reads back the pending bits (bit 0 always 0). Bus writes to it have no effect.
- R9: The enable word stores wdata[31:1], and bit 0 reads as 0. The other words in a context's 0x80-byte enable window read 0 and ignore writes.
- R10: A rising edge on src_i[n-1] sets the pending bit of source n unless source n is currently claimed. In that case the edge is lost.
- R11: After reset, all priorities, thresholds, enables, pending and claimed bits are 0, and every irq_o is low.
- R12: Unmapped or misaligned addresses read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 31 | Source request lines; bit n-1 is source n |
| req_valid_i | input | 1 | Bus access strobe, one cycle per access |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 22 | Byte address |
| req_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 2 | Interrupt line per context |

## Verification
A claimed bit that stays set by mistake would not appear on irq_o right away. It shows up at the next edge on that source, because the pending word does not change and the source is never offered again. The bench therefore re-pulses sources after claims and after both valid and out-of-range completions. A wrong priority comparison or tie order shows up in the ID returned by the very next claim read. An incorrect pending or enable state shows on irq_o one cycle after the state changes. The bench drains every context after randomly mixed priority, enable and threshold patterns, and compares each claimed ID with an arithmetic model of the selection rule.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int ADDR_W = 22;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    HIT_NONE,
    HIT_PRIO,
    HIT_PEND,
    HIT_EN,
    HIT_THR,
    HIT_CLAIM
  } hit_e;
endpackage

// File: rtl/ipc_rst_sync.sv
module ipc_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/ipc_gateway.sv
// Edge capture, pending and in-service tracking for all sources.
module ipc_gateway #(
  parameter int LW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] src_i,
  input  logic [LW-1:0] claim_i,
  input  logic [LW-1:0] done_i,
  output logic [LW-1:0] pend_o,
  output logic [LW-1:0] clm_o
);
  logic [LW-1:0] src_q, pend_q, clm_q;
  logic [LW-1:0] pend_n, clm_n, rise;

  always_comb begin
    rise   = src_i & ~src_q;
    pend_n = (pend_q | (rise & ~clm_q)) & ~claim_i;
    clm_n  = (clm_q | claim_i) & ~done_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
      clm_q  <= '0;
    end else begin
      src_q  <= src_i;
      pend_q <= pend_n;
      clm_q  <= clm_n;
    end
  end

  assign pend_o = pend_q;
  assign clm_o  = clm_q;

  // R10: a source is never pending and claimed at once
  a_r10_pend_clm_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & clm_q) == '0);

  // R5: a completion releases the source on the next cycle
  a_r5_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i != '0) |=> ((clm_q & $past(done_i)) == '0));
endmodule

// File: rtl/ipc_winner.sv
// Priority scan for one context: first strict maximum above threshold.
module ipc_winner #(
  parameter int LW  = 32,
  parameter int PW  = 3,
  parameter int IDW = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LW-1:0]          cand_i,
  input  logic [LW-1:0][PW-1:0]  prio_i,
  input  logic [PW-1:0]          thr_i,
  output logic [IDW-1:0]         win_o
);
  logic [PW-1:0] best_p;

  always_comb begin
    best_p = thr_i;
    win_o  = '0;
    for (int i = 1; i < LW; i++) begin
      if (cand_i[i] && (prio_i[i] > best_p)) begin
        best_p = prio_i[i];
        win_o  = IDW'(i);
      end
    end
  end

  // R2: a non-zero result is an eligible source above threshold
  a_r2_winner_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (win_o != '0) |-> (cand_i[win_o] && (prio_i[win_o] > thr_i)));
endmodule

// File: rtl/irq_claim_ctrl.sv
module irq_claim_ctrl #(
  parameter int NSRC = 31,
  parameter int NCTX = 2,
  parameter int PW   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSRC-1:0]            src_i,
  input  logic                       req_valid_i,
  input  logic                       req_write_i,
  input  logic [ipc_pkg::ADDR_W-1:0] req_addr_i,
  input  logic [ipc_pkg::DATA_W-1:0] req_wdata_i,
  output logic [ipc_pkg::DATA_W-1:0] rd_data_o,
  output logic [NCTX-1:0]            irq_o
);
  import ipc_pkg::*;

  localparam int LW   = NSRC + 1;
  localparam int IDW  = $clog2(LW);
  localparam int MAXP = (1 << PW) - 1;
  localparam int CB   = (NCTX > 1) ? $clog2(NCTX) : 1;
  localparam logic [LW-1:0] ONE = {{(LW-1){1'b0}}, 1'b1};

  logic rst_s;
  ipc_rst_sync u_rst (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_s));

  // register state
  logic [LW-1:0][PW-1:0]   prio_q, prio_n;
  logic [NCTX-1:0][PW-1:0] thr_q, thr_n;
  logic [NCTX-1:0][LW-1:0] en_q, en_n;
  logic [DATA_W-1:0]       rd_q, rd_n;
  logic [NCTX-1:0]         irq_q, irq_n;

  logic [LW-1:0]  pend, clm, claim_vec, done_vec;
  logic [IDW-1:0] win_id [NCTX];
  logic [IDW-1:0] claim_id;
  hit_e           hit;
  logic [IDW-1:0] sel_src;
  logic [CB-1:0]  sel_ctx;
  logic           wr, rdn;

  assign wr  = req_valid_i & req_write_i;
  assign rdn = req_valid_i & ~req_write_i;

  // address decode
  always_comb begin
    hit     = HIT_NONE;
    sel_src = '0;
    sel_ctx = '0;
    if (req_addr_i[1:0] == 2'b00) begin
      if (!req_addr_i[21]) begin
        if (req_addr_i[20:14] == '0) begin
          case (req_addr_i[13:12])
            2'd0: if (int'(req_addr_i[11:2]) < NSRC) begin
              hit     = HIT_PRIO;
              sel_src = IDW'(int'(req_addr_i[11:2]) + 1);
            end
            2'd1: if (req_addr_i[11:2] == '0) hit = HIT_PEND;
            2'd2: if ((int'(req_addr_i[11:7]) < NCTX) && (req_addr_i[6:2] == '0)) begin
              hit     = HIT_EN;
              sel_ctx = req_addr_i[7 +: CB];
            end
            default: ;
          endcase
        end
      end else if ((req_addr_i[20:12+CB] == '0) && (int'(req_addr_i[12 +: CB]) < NCTX)) begin
        sel_ctx = req_addr_i[12 +: CB];
        if (req_addr_i[11:2] == 10'd0)      hit = HIT_THR;
        else if (req_addr_i[11:2] == 10'd1) hit = HIT_CLAIM;
      end
    end
  end

  // claim / completion requests into the gateway
  always_comb begin
    claim_id  = win_id[sel_ctx];
    claim_vec = '0;
    done_vec  = '0;
    if (rdn && (hit == HIT_CLAIM) && (claim_id != '0))
      claim_vec = ONE << claim_id;
    if (wr && (hit == HIT_CLAIM) && (req_wdata_i < 32'(LW)))
      done_vec = (ONE << req_wdata_i[IDW-1:0]) & ~ONE;
  end

  ipc_gateway #(.LW(LW)) u_gate (
    .clk     (clk),
    .rst_n   (rst_s),
    .src_i   ({src_i, 1'b0}),
    .claim_i (claim_vec),
    .done_i  (done_vec),
    .pend_o  (pend),
    .clm_o   (clm)
  );

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    logic [LW-1:0] cand;
    assign cand = pend & ~clm & en_q[c];

    ipc_winner #(.LW(LW), .PW(PW), .IDW(IDW)) u_win (
      .clk    (clk),
      .rst_n  (rst_s),
      .cand_i (cand),
      .prio_i (prio_q),
      .thr_i  (thr_q[c]),
      .win_o  (win_id[c])
    );

    assign irq_n[c] = (win_id[c] != '0);

    // R3: no eligible source means the line is low next cycle
    a_r3_irq_idle: assert property (@(posedge clk) disable iff (!rst_s)
      ((pend & ~clm & en_q[c]) == '0) |=> !irq_o[c]);
  end

  // next-state for configuration and read data
  always_comb begin
    prio_n = prio_q;
    thr_n  = thr_q;
    en_n   = en_q;
    rd_n   = rd_q;
    if (wr) begin
      case (hit)
        HIT_PRIO: prio_n[sel_src] = req_wdata_i[PW-1:0];
        HIT_THR:  if (req_wdata_i <= 32'(MAXP)) thr_n[sel_ctx] = req_wdata_i[PW-1:0];
        HIT_EN:   en_n[sel_ctx] = {req_wdata_i[LW-1:1], 1'b0};
        default: ;
      endcase
    end
    if (rdn) begin
      case (hit)
        HIT_PRIO:  rd_n = DATA_W'(prio_q[sel_src]);
        HIT_PEND:  rd_n = DATA_W'(pend);
        HIT_EN:    rd_n = DATA_W'(en_q[sel_ctx]);
        HIT_THR:   rd_n = DATA_W'(thr_q[sel_ctx]);
        HIT_CLAIM: rd_n = DATA_W'(claim_id);
        default:   rd_n = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      prio_q <= '0;
      thr_q  <= '0;
      en_q   <= '0;
      rd_q   <= '0;
      irq_q  <= '0;
    end else begin
      if (wr)  prio_q <= prio_n;
      if (wr)  thr_q  <= thr_n;
      if (wr)  en_q   <= en_n;
      if (rdn) rd_q   <= rd_n;
      irq_q <= irq_n;
    end
  end

  assign rd_data_o = rd_q;
  assign irq_o     = irq_q;

  // R4: a claim returns the selected ID on the following cycle
  a_r4_claim_returns: assert property (@(posedge clk) disable iff (!rst_s)
    (rdn && (hit == HIT_CLAIM) && (claim_id != '0)) |=>
      (rd_data_o == DATA_W'($past(claim_id))));

  // R7: out-of-range threshold writes leave all thresholds unchanged
  a_r7_thr_limit: assert property (@(posedge clk) disable iff (!rst_s)
    (wr && (hit == HIT_THR) && (req_wdata_i > 32'(MAXP))) |=> $stable(thr_q));
endmodule

// File: tb/irq_claim_ctrl_tb_top.sv
module irq_claim_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [30:0] src;
  logic        req_valid, req_write;
  logic [21:0] req_addr;
  logic [31:0] req_wdata;
  logic [31:0] rd_data;
  logic [1:0]  irq;

  irq_claim_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // bench model
  int        m_prio [32];
  int        m_thr  [2];
  bit [31:0] m_en   [2];
  bit [31:0] m_pend, m_clm;
  bit [31:0] seed = 32'h1234_5678;

  function automatic bit [31:0] lcg();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  function automatic [21:0] a_prio(int s);  return 22'((s - 1) * 4);          endfunction
  function automatic [21:0] a_en(int c);    return 22'(32'h2000 + c * 32'h80); endfunction
  function automatic [21:0] a_thr(int c);   return 22'(32'h200000 + c * 32'h1000); endfunction
  function automatic [21:0] a_clm(int c);   return a_thr(c) + 22'd4;          endfunction
  localparam logic [21:0] A_PEND = 22'h001000;

  function automatic int exp_win(int c);
    int best = m_thr[c];
    int id = 0;
    for (int s = 1; s < 32; s++)
      if (m_pend[s] && !m_clm[s] && m_en[c][s] && m_prio[s] > best) begin
        best = m_prio[s];
        id = s;
      end
    return id;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [21:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(logic [21:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rd_data;
  endtask

  task automatic set_prio(int s, logic [31:0] v);
    bus_wr(a_prio(s), v);
    m_prio[s] = int'(v[2:0]);
  endtask

  task automatic set_thr(int c, logic [31:0] v);
    bus_wr(a_thr(c), v);
    if (v <= 32'd7) m_thr[c] = int'(v);
  endtask

  task automatic set_en(int c, logic [31:0] v);
    bus_wr(a_en(c), v);
    m_en[c] = v & ~32'd1;
  endtask

  task automatic pulse(bit [31:0] mask);
    @(negedge clk);
    src = mask[31:1];
    @(negedge clk);
    src = '0;
    m_pend = m_pend | (mask & ~m_clm & ~32'd1);
  endtask

  task automatic do_claim(int c, output int got);
    logic [31:0] d;
    int e;
    e = exp_win(c);
    bus_rd(a_clm(c), d);
    check("R1 R2 R4 claim id", d, 32'(e));
    if (e != 0) begin
      m_pend[e] = 1'b0;
      m_clm[e]  = 1'b1;
    end
    got = e;
  endtask

  task automatic do_done(int c, logic [31:0] v);
    bus_wr(a_clm(c), v);
    if (v < 32) m_clm[v[4:0]] = 1'b0;
  endtask

  task automatic check_irq(string tag);
    @(negedge clk);
    for (int c = 0; c < 2; c++)
      check(tag, 32'(irq[c]), 32'(exp_win(c) != 0));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    int got;
    rst_n = 1'b0; src = '0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    for (int s = 0; s < 32; s++) m_prio[s] = 0;
    m_thr[0] = 0; m_thr[1] = 0; m_en[0] = 0; m_en[1] = 0;
    m_pend = 0; m_clm = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    check("R11 irq", 32'(irq), 32'd0);
    bus_rd(A_PEND, d);    check("R11 pending", d, 0);
    bus_rd(a_prio(1), d); check("R11 prio", d, 0);
    bus_rd(a_thr(1), d);  check("R11 thr", d, 0);
    bus_rd(a_en(0), d);   check("R11 en", d, 0);
    bus_rd(a_clm(0), d);  check("R11 claim", d, 0);

    // R6 priority storage sweep
    for (int s = 1; s < 32; s++) set_prio(s, 32'(s * 37 + 32'hFFF0_0100));
    for (int s = 1; s < 32; s++) begin
      bus_rd(a_prio(s), d);
      check("R6 prio readback", d, 32'(m_prio[s]));
    end

    // R12 unmapped / misaligned
    bus_rd(22'h00007C, d);              check("R12 prio beyond last", d, 0);
    bus_rd(a_prio(1) + 22'd1, d);       check("R12 misaligned rd", d, 0);
    bus_wr(a_prio(2) + 22'd2, 32'd5);
    bus_rd(a_prio(2), d);               check("R12 misaligned wr", d, 32'(m_prio[2]));
    bus_rd(22'h203000, d);              check("R12 ctx beyond last", d, 0);

    // R7 threshold sweep
    for (int v = 0; v < 13; v++) begin
      set_thr(0, 32'(v));
      bus_rd(a_thr(0), d);
      check("R7 thr", d, 32'(m_thr[0]));
    end
    set_thr(0, 32'h0000_0100);
    bus_rd(a_thr(0), d); check("R7 thr wide", d, 32'(m_thr[0]));
    set_thr(0, 0);

    // R9 enable window
    set_en(1, 32'hFFFF_FFFF);
    bus_rd(a_en(1), d);            check("R9 en bit0", d, 32'hFFFF_FFFE);
    bus_wr(a_en(1) + 22'd4, 32'h1234);
    bus_rd(a_en(1) + 22'd4, d);    check("R9 en extra word", d, 0);
    bus_rd(a_en(1), d);            check("R9 en unchanged", d, 32'hFFFF_FFFE);
    set_en(1, 0);

    // R8 / R10 pending capture and read-only
    for (int s = 1; s < 32; s++) set_prio(s, 0);
    pulse(32'h0000_8412);
    bus_rd(A_PEND, d);             check("R10 pending set", d, m_pend);
    bus_wr(A_PEND, 32'h0);
    bus_rd(A_PEND, d);             check("R8 pending read-only", d, m_pend);
    check("R3 prio0 no irq", 32'(irq), 0);

    // R2 tie -> lowest ID; threshold strictness
    set_prio(7, 4); set_prio(9, 4); set_en(0, 32'h0000_0280);
    pulse(32'h0000_0280);
    set_thr(0, 4);
    check_irq("R2 R3 prio equal thr");
    set_thr(0, 3);
    check_irq("R3 above thr");
    do_claim(0, got); check("R2 tie lowest", 32'(got), 32'd7);
    do_claim(0, got); check("R2 second", 32'(got), 32'd9);
    do_claim(0, got); check("R2 empty", 32'(got), 32'd0);
    do_done(0, 7); do_done(1, 9);
    set_thr(0, 0);

    // R10 / R5 claimed masking and completion range
    set_prio(5, 3); set_en(0, 32'h20);
    pulse(32'h20);
    check_irq("R3 src5");
    do_claim(0, got); check("R4 claim src5", 32'(got), 32'd5);
    check_irq("R3 after claim");
    pulse(32'h20);
    bus_rd(A_PEND, d); check("R10 edge while claimed", d & 32'h20, 0);
    do_done(0, 32'd37);
    pulse(32'h20);
    bus_rd(A_PEND, d); check("R5 large id ignored", d & 32'h20, 0);
    do_done(0, 32'd5);
    pulse(32'h20);
    bus_rd(A_PEND, d); check("R5 released", d & 32'h20, 32'h20);
    check_irq("R3 re-raised");
    do_claim(0, got);
    do_done(0, 32'd5);

    // randomized sweep, drained each round
    for (int r = 0; r < 40; r++) begin
      for (int s = 1; s < 32; s++) set_prio(s, lcg() >> 20);
      set_thr(0, (lcg() >> 24) % 9);
      set_thr(1, (lcg() >> 24) % 9);
      set_en(0, lcg());
      set_en(1, lcg());
      pulse(lcg());
      check_irq("R1 R3 sweep");
      for (int c = 0; c < 2; c++) begin
        for (int k = 0; k < 32; k++) begin
          do_claim(c, got);
          if (got == 0) break;
        end
      end
      check_irq("R3 drained");
      for (int s = 1; s < 32; s++)
        if (m_clm[s]) do_done(int'(lcg() >> 31), 32'(s));
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule